// File: doc/BRIEF.md
# Inter-Processor Interrupt Crossbar

This block lets eleven agents raise interrupts at one another through a small register bus. Each agent owns a register window with six registers:

- a write-only trigger register that posts requests to peers;
- an observation register that shows which of its own requests are still outstanding;
- a status register that shows which peers have requested it, cleared by writing ones;
- a read-only mask register;
- enable and disable registers that clear or set mask bits.

Every agent has one interrupt output. That output is high while the agent has any pending status bit that is not masked.

Agents are named by sparse one-hot bit positions in a 32-bit word. The same bit names an agent whether it sends or receives. Four agents are secure-only. A non-secure access to one of their windows is rejected. A non-secure trigger that names one of them as a destination is also rejected. A rejected access changes no state, reads as zero and raises the error output.

The bus has no handshake and takes one access per cycle. Read data and the error flag are registered and appear in the cycle after the access.

Top module: `ipi_xbar`

## Requirements
- R1: The byte address selects the window by its agent index in bits [8:5] and the register by its offset in bits [4:0]. The offsets are trigger 0x00, observation 0x04, status 0x10, mask 0x14, enable 0x18 and disable 0x1C. Read data and the error flag are valid in the cycle after the access.
- R2: Agent index k maps to the k-th lowest of the bit positions {0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27}. All other bits read as zero and have no effect when written.
- R3: A write of bit B to agent A's trigger register sets bit A in agent B's status register and bit B in agent A's observation register. Receive pending and send pending are therefore visible independently.
- R4: Writing a 1 to bit A of agent B's status register clears that status bit. It also clears bit B of agent A's observation register.
- R5: Every mask register resets to all ones (0x0F0F0301) and cannot be written directly. Ones written to enable clear mask bits and ones written to disable set them. Zeros written to either register change nothing.
- R6: Interrupt output i equals the OR of (status AND NOT mask) for agent i, registered one cycle after the state. Status bits latch whether or not they are masked.
- R7: The trigger, enable and disable registers read as zero. So do the unused offsets 0x08 and 0x0C.
- R8: Agents 3 to 6 (bits 16 to 19) are secure-only. A non-secure access to their windows raises the error flag, reads as zero and changes no state.
- R9: A non-secure trigger write whose data includes any secure-only agent bit is rejected as a whole. The error flag is raised and no status changes.
- R10: An access to an agent index of 11 or above raises the error flag and reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address: agent index [8:5], offset [4:0] |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access carries the secure attribute |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered flag for a rejected access |
| irq | output | 11 | Per-agent interrupt, indexed by agent index |

## Verification
The bound checker watches several rules on every cycle:

- a non-secure access to a secure window or to a missing window always produces the error flag;
- such a write leaves the status and mask state untouched;
- a flagged access returns zero;
- the write-only registers read as zero;
- each interrupt follows the previous cycle's unmasked status.

The cross-coupling of trigger, observation and acknowledge between every ordered pair of agents can only be shown by the bench's sweep. The same holds for the exact mask arithmetic of enable and disable, and for whole-write rejection when a trigger names a secure agent.

// File: rtl/ipi_xbar_pkg.sv
package ipi_xbar_pkg;

  localparam int NUM_AGENTS = 11;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 9;
  localparam int OFF_W      = 5;

  typedef enum logic [2:0] {
    RS_TRIG,
    RS_OBS,
    RS_STAT,
    RS_MASK,
    RS_EN,
    RS_DIS,
    RS_NONE
  } reg_sel_e;

  // Bit lane of agent k in a 32-bit word (sparse one-hot identifiers).
  function automatic int lane_of(input int k);
    if (k == 0)     return 0;
    else if (k < 3) return k + 7;
    else if (k < 7) return k + 13;
    else            return k + 17;
  endfunction

  // Agents reachable only by secure accesses.
  function automatic bit is_secure_agent(input int k);
    return (k >= 3) && (k <= 6);
  endfunction

endpackage

// File: rtl/ipi_lane_map.sv
module ipi_lane_map
  import ipi_xbar_pkg::*;
#(
  parameter int N  = NUM_AGENTS,
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] word_in,
  output logic [N-1:0]  vec_out,
  input  logic [N-1:0]  vec_in,
  output logic [DW-1:0] word_out
);

  // Gather: bus word to compact agent vector.
  for (genvar k = 0; k < N; k++) begin : g_gather
    assign vec_out[k] = word_in[lane_of(k)];
  end

  // Scatter: compact agent vector to bus word; undefined lanes stay zero.
  always_comb begin
    word_out = '0;
    for (int k = 0; k < N; k++) begin
      word_out[lane_of(k)] = vec_in[k];
    end
  end

endmodule

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_xbar_pkg::*;
#(
  parameter int N  = NUM_AGENTS,
  parameter int AW = ADDR_W,
  localparam int IW = AW - OFF_W
) (
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          secure,
  input  logic [N-1:0]  wvec,
  output logic [IW-1:0] agent_idx,
  output reg_sel_e      rsel,
  output logic          accept,
  output logic          reject
);

  logic [N-1:0] sec_vec;
  logic         in_range;
  logic         sec_win;
  logic         names_sec;

  for (genvar k = 0; k < N; k++) begin : g_sec
    assign sec_vec[k] = is_secure_agent(k);
  end

  assign agent_idx = addr[AW-1:OFF_W];
  assign in_range  = (int'(agent_idx) < N);
  assign sec_win   = in_range && (is_secure_agent(int'(agent_idx)) != 1'b0);

  always_comb begin
    unique case (addr[OFF_W-1:2])
      3'd0:    rsel = RS_TRIG;
      3'd1:    rsel = RS_OBS;
      3'd4:    rsel = RS_STAT;
      3'd5:    rsel = RS_MASK;
      3'd6:    rsel = RS_EN;
      3'd7:    rsel = RS_DIS;
      default: rsel = RS_NONE;
    endcase
  end

  assign names_sec = we && (rsel == RS_TRIG) && (|(wvec & sec_vec));
  assign reject    = sel && (!in_range || (!secure && (sec_win || names_sec)));
  assign accept    = sel && !reject;

endmodule

// File: rtl/ipi_state.sv
module ipi_state
  import ipi_xbar_pkg::*;
#(
  parameter int N  = NUM_AGENTS,
  parameter int IW = ADDR_W - OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                we,
  input  logic [IW-1:0]       agent_idx,
  input  reg_sel_e            rsel,
  input  logic [N-1:0]        wvec,
  output logic [N-1:0][N-1:0] stat_q,
  output logic [N-1:0][N-1:0] mask_q,
  output logic [N-1:0]        rvec,
  output logic [N-1:0]        irq_q
);

  // stat_q[dst][src]: src has a request pending toward dst.
  logic [N-1:0][N-1:0] set_m, clr_m, mask_d;
  logic                wr;

  assign wr = accept && we;

  always_comb begin
    for (int d = 0; d < N; d++) begin
      for (int s = 0; s < N; s++) begin
        set_m[d][s] = wr && (rsel == RS_TRIG) && (agent_idx == IW'(s)) && wvec[d];
        clr_m[d][s] = wr && (rsel == RS_STAT) && (agent_idx == IW'(d)) && wvec[s];
      end
    end
  end

  always_comb begin
    mask_d = mask_q;
    for (int i = 0; i < N; i++) begin
      if (wr && (agent_idx == IW'(i))) begin
        if (rsel == RS_EN)  mask_d[i] = mask_q[i] & ~wvec;
        if (rsel == RS_DIS) mask_d[i] = mask_q[i] | wvec;
      end
    end
  end

  // Read mux; the observation view is the transpose of the status matrix.
  always_comb begin
    rvec = '0;
    if (int'(agent_idx) < N) begin
      unique case (rsel)
        RS_OBS:  for (int j = 0; j < N; j++) rvec[j] = stat_q[j][agent_idx];
        RS_STAT: rvec = stat_q[agent_idx];
        RS_MASK: rvec = mask_q[agent_idx];
        default: rvec = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_m) | set_m;   // set wins over clear
      mask_q <= mask_d;
      for (int i = 0; i < N; i++) begin
        irq_q[i] <= |(stat_q[i] & ~mask_q[i]);
      end
    end
  end

endmodule

// File: rtl/ipi_xbar.sv
module ipi_xbar
  import ipi_xbar_pkg::*;
#(
  parameter int N_AGENTS = NUM_AGENTS,
  parameter int AW       = ADDR_W,
  parameter int DW       = DATA_W,
  localparam int IW      = AW - OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_secure,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_err,
  output logic [N_AGENTS-1:0] irq
);

  logic [N_AGENTS-1:0]               wvec, rvec;
  logic [DW-1:0]                     rword;
  logic [IW-1:0]                     agent_idx;
  reg_sel_e                          rsel;
  logic                              accept, reject;
  logic [N_AGENTS-1:0][N_AGENTS-1:0] stat_q, mask_q;

  ipi_lane_map #(.N(N_AGENTS), .DW(DW)) u_map (
    .word_in (bus_wdata),
    .vec_out (wvec),
    .vec_in  (rvec),
    .word_out(rword)
  );

  ipi_decode #(.N(N_AGENTS), .AW(AW)) u_dec (
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .secure   (bus_secure),
    .wvec     (wvec),
    .agent_idx(agent_idx),
    .rsel     (rsel),
    .accept   (accept),
    .reject   (reject)
  );

  ipi_state #(.N(N_AGENTS), .IW(IW)) u_st (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .we       (bus_we),
    .agent_idx(agent_idx),
    .rsel     (rsel),
    .wvec     (wvec),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .rvec     (rvec),
    .irq_q    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= reject;
      bus_rdata <= (accept && !bus_we) ? rword : '0;
    end
  end

endmodule

// File: rtl/ipi_xbar_chk.sv
module ipi_xbar_chk
  import ipi_xbar_pkg::*;
#(
  parameter int N  = NUM_AGENTS,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic                bus_secure,
  input logic [DW-1:0]       bus_rdata,
  input logic                bus_err,
  input logic [N-1:0]        irq,
  input logic [N-1:0][N-1:0] stat_q,
  input logic [N-1:0][N-1:0] mask_q
);

  int           idx;
  logic         ns_sec_win, bad_idx, wo_read;
  logic [N-1:0] exp_irq;

  assign idx        = int'(bus_addr[AW-1:OFF_W]);
  assign ns_sec_win = bus_sel && !bus_secure && (idx >= 3) && (idx <= 6);
  assign bad_idx    = bus_sel && (idx >= N);
  assign wo_read    = bus_sel && !bus_we &&
                      ((bus_addr[4:2] == 3'd0) || (bus_addr[4:2] == 3'd6) ||
                       (bus_addr[4:2] == 3'd7));

  always_comb begin
    for (int i = 0; i < N; i++) exp_irq[i] = |(stat_q[i] & ~mask_q[i]);
  end

  // R8
  sec_err_chk: assert property (@(posedge clk) disable iff (rst)
    ns_sec_win |=> bus_err);

  // R8
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_sec_win && bus_we) |=> (stat_q == $past(stat_q)) && (mask_q == $past(mask_q)));

  // R10
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    bad_idx |=> bus_err);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));

  // R7
  wo_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wo_read |=> (bus_rdata == '0));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(exp_irq)));

endmodule

bind ipi_xbar ipi_xbar_chk #(.N(N_AGENTS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_secure(bus_secure),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .irq       (irq),
  .stat_q    (stat_q),
  .mask_q    (mask_q)
);

// File: tb/tb_ipi_xbar.sv
module tb_ipi_xbar;

  localparam int N = 11;
  localparam int LANE [N] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  localparam logic [31:0] ALL_DEF = 32'h0F0F_0301;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_secure = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [N-1:0] irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_xbar dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input int idx, input int off, input logic we, input logic [31:0] wd,
                     input logic sec, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = 9'(idx * 32 + off);
    bus_wdata = wd; bus_secure = sec;
    @(posedge clk);
    #1;
    rd = bus_rdata; er = bus_err;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] bitof(input int k);
    return 32'h1 << LANE[k];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;

    // Reset state (R5, R6)
    chk("R6 irq after reset", 32'(irq), 32'h0);
    acc(0, 'h14, 0, 0, 1, rd, er); chk("R5 mask reset", rd, ALL_DEF);
    acc(0, 'h10, 0, 0, 1, rd, er); chk("R1 stat reset", rd, 32'h0);

    // Full pair sweep (R1, R2, R3, R4)
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        acc(a, 'h00, 1, bitof(b), 1, rd, er); chk("R3 trig err", 32'(er), 0);
        acc(b, 'h10, 0, 0, 1, rd, er);        chk("R3 recv pending", rd, bitof(a));
        acc(a, 'h04, 0, 0, 1, rd, er);        chk("R3 send pending", rd, bitof(b));
        acc(b, 'h10, 1, bitof(a), 1, rd, er);
        acc(a, 'h04, 0, 0, 1, rd, er);        chk("R4 obs cleared", rd, 32'h0);
        acc(b, 'h10, 0, 0, 1, rd, er);        chk("R4 stat cleared", rd, 32'h0);
      end
    end

    // Undefined lanes ignored (R2)
    acc(0, 'h00, 1, 32'hF0F0_F0FE, 1, rd, er); chk("R2 undef trig err", 32'(er), 0);
    acc(0, 'h04, 0, 0, 1, rd, er);             chk("R2 undef trig no obs", rd, 32'h0);

    // Write-only and unused offsets read zero (R7)
    acc(2, 'h00, 1, bitof(0), 1, rd, er);
    acc(2, 'h00, 0, 0, 1, rd, er); chk("R7 trig reads zero", rd, 0);
    acc(2, 'h18, 0, 0, 1, rd, er); chk("R7 enable reads zero", rd, 0);
    acc(2, 'h1C, 0, 0, 1, rd, er); chk("R7 disable reads zero", rd, 0);
    acc(2, 'h08, 0, 0, 1, rd, er); chk("R7 unused reads zero", rd, 0);
    acc(0, 'h10, 1, bitof(2), 1, rd, er);

    // Mask arithmetic (R5)
    acc(1, 'h18, 1, bitof(0) | bitof(1), 1, rd, er);
    acc(1, 'h14, 0, 0, 1, rd, er); chk("R5 enable clears", rd, ALL_DEF & ~(bitof(0) | bitof(1)));
    acc(1, 'h1C, 1, 0, 1, rd, er);
    acc(1, 'h18, 1, 0, 1, rd, er);
    acc(1, 'h14, 1, 0, 1, rd, er);
    acc(1, 'h14, 0, 0, 1, rd, er); chk("R5 zeros and direct write ignored", rd, ALL_DEF & ~(bitof(0) | bitof(1)));
    acc(1, 'h1C, 1, bitof(1), 1, rd, er);
    acc(1, 'h14, 0, 0, 1, rd, er); chk("R5 disable sets", rd, ALL_DEF & ~bitof(0));

    // Interrupt path (R6)
    acc(2, 'h00, 1, bitof(1), 1, rd, er);   // masked source
    @(posedge clk); #1;
    chk("R6 masked source no irq", 32'(irq), 0);
    acc(1, 'h10, 0, 0, 1, rd, er); chk("R6 status latches while masked", rd, bitof(2));
    acc(0, 'h00, 1, bitof(1), 1, rd, er);   // unmasked source
    chk("R6 irq one cycle late", 32'(irq), 0);
    @(posedge clk); #1;
    chk("R6 irq raised", 32'(irq), 32'h2);
    acc(1, 'h1C, 1, bitof(0), 1, rd, er);
    @(posedge clk); #1;
    chk("R6 irq masked off", 32'(irq), 0);
    acc(1, 'h18, 1, bitof(2), 1, rd, er);
    @(posedge clk); #1;
    chk("R6 irq by other source", 32'(irq), 32'h2);
    acc(1, 'h10, 1, bitof(0) | bitof(2), 1, rd, er);
    @(posedge clk); #1;
    chk("R6 irq drops after ack", 32'(irq), 0);

    // Secure windows (R8)
    acc(3, 'h14, 0, 0, 0, rd, er);
    chk("R8 ns read err", 32'(er), 1); chk("R8 ns read zero", rd, 0);
    acc(4, 'h18, 1, 32'hFFFF_FFFF, 0, rd, er); chk("R8 ns write err", 32'(er), 1);
    acc(4, 'h14, 0, 0, 1, rd, er);
    chk("R8 mask unchanged", rd, ALL_DEF); chk("R8 secure ok", 32'(er), 0);
    acc(6, 'h00, 1, bitof(0), 0, rd, er);
    acc(0, 'h10, 0, 0, 1, rd, er); chk("R8 ns trig from secure window ignored", rd, 0);
    acc(7, 'h14, 0, 0, 0, rd, er); chk("R8 ns non-secure window ok", 32'(er), 0);

    // Trigger naming a secure agent (R9)
    acc(0, 'h00, 1, bitof(1) | bitof(3), 0, rd, er); chk("R9 ns trig err", 32'(er), 1);
    acc(1, 'h10, 0, 0, 1, rd, er); chk("R9 whole write rejected", rd, 0);
    acc(3, 'h10, 0, 0, 1, rd, er); chk("R9 secure target untouched", rd, 0);
    acc(0, 'h00, 1, bitof(1), 0, rd, er); chk("R9 ns trig plain ok", 32'(er), 0);
    acc(1, 'h10, 0, 0, 1, rd, er); chk("R9 ns trig delivered", rd, bitof(0));
    acc(1, 'h10, 1, bitof(0), 0, rd, er);

    // Missing windows (R10)
    acc(11, 'h14, 0, 0, 1, rd, er);
    chk("R10 idx11 err", 32'(er), 1); chk("R10 idx11 zero", rd, 0);
    acc(15, 'h04, 0, 0, 1, rd, er); chk("R10 idx15 err", 32'(er), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule